// File: doc/BRIEF.md
# Frame-Slipping Transmit Elastic Store

This block is a bit-serial elastic store for a 193-bit-frame transmit path. Bits arrive on the system side under a write clock, one bit per cycle in which the write enable is high. They leave on the line side under an independent read clock, one bit per cycle in which the read enable is high. A 2-bit size code selects how much of the store is in use. The store can be bypassed, used as a single frame (193 bits) or used as two frames (386 bits).

The write pointer crosses into the read domain as a Gray code through a two-flop synchroniser. The read side measures the fill level from that copy. When the two rates drift apart until the store runs dry or overfills, the read side slips by exactly one whole frame, so frame alignment is kept. On underflow it repeats the previous frame, and on overflow it skips ahead one frame. Each slip sets a sticky, write-1-to-clear status flag that records its direction, and unmasked flags drive an interrupt.

Writing an offset value sets the separation between the two pointers. After reset the pointers start half the selected size apart.

Top module: `tx_frame_store`

## Requirements
- R1: With size code 00 the store is bypassed: `ser_out` equals the value `ser_in` had at the previous rising edge of `rclk`, and no slip flag is ever set.
- R2: Size code 01 gives a capacity of 193 bits. Codes 10 and 11 both give a capacity of 386 bits, and in those modes an overflow slip needs a fill of 386 or more.
- R3: On a read step where the fill is 0 or negative, an underflow slip occurs. The bit output is the one stored 193 positions before the current read position, reading continues from there, and status bit 0 is set.
- R4: On a read step where the fill is at least the capacity, an overflow slip occurs. The bit output is the one stored 193 positions after the current read position, reading continues from there, and status bit 1 is set.
- R5: With no slip, each read step outputs the next stored bit in write order, registered on `rclk`. When `rd_en` is low, `ser_out` holds its value.
- R6: The fill is the write count taken two `rclk` edges earlier (two-flop Gray synchroniser) minus the read position. The Gray-coded write pointer changes by at most one bit per write-clock edge.
- R7: During and after reset, `slip_stat` is 00 and `irq` is 0. The read position starts half the capacity (rounded down) behind the write position.
- R8: A cycle with `offs_load` high sets the read position to the synchronised write count minus `offs_val` when 1 <= `offs_val` <= capacity-1. For any other value it uses half the capacity. No read step is taken in that cycle, and `ser_out` holds.
- R9: Slip flags are sticky. A 1 written to a bit of `stat_clr` clears that bit, but a slip in the same cycle wins. An underflow slip and an overflow slip never occur in the same cycle.
- R10: `irq` is high after an edge exactly when some bit of `slip_stat` is 1 and the matching `irq_mask` bit (sampled at that edge) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | System-side write clock |
| rclk | input | 1 | Line-side read clock |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| size_sel | input | 2 | Size code: 00 bypass, 01 one frame, 10/11 two frames |
| wr_en | input | 1 | Write one bit this `wclk` cycle |
| ser_in | input | 1 | Serial input bit (written on `wclk`; sampled on `rclk` in bypass) |
| rd_en | input | 1 | Read one bit this `rclk` cycle |
| offs_load | input | 1 | Load the pointer separation from `offs_val` (`rclk` domain) |
| offs_val | input | 10 | Requested separation in bits |
| stat_clr | input | 2 | Write-1-to-clear for `slip_stat` |
| irq_mask | input | 2 | Interrupt mask, 1 = masked |
| ser_out | output | 1 | Serial output bit |
| slip_stat | output | 2 | Sticky slip flags: bit 0 underflow, bit 1 overflow |
| irq | output | 1 | Interrupt, high while an unmasked flag is set |

## Verification
Some properties are checked by assertions on every cycle: flags stay set until cleared, at most one slip direction per cycle, the interrupt always has a set flag behind it, the bypass path has a one-register latency and sets no flag, the Gray pointer changes by one bit per step, and the state is clean after reset.

Other behaviour only the bench scenarios can show. They check that a slip happens at exactly the fill threshold seen through the two-stage synchroniser, and that the repeated or skipped frame is exactly 193 bits away. They also check the in-order output stream, the effect of offset loads including out-of-range values, and the different capacity of each size code. For this the bench drives rate mismatches in both directions.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

  typedef enum logic [1:0] {
    SZ_BYPASS = 2'b00,
    SZ_ONE    = 2'b01,
    SZ_TWO    = 2'b10,
    SZ_TWO_B  = 2'b11
  } size_code_e;

  localparam int STAT_UNDER = 0;
  localparam int STAT_OVER  = 1;

endpackage

// File: rtl/tfs_wr_ctrl.sv
module tfs_wr_ctrl #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wen,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] wr_gray
);

  logic [PW-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = wr_ptr + {{(PW-1){1'b0}}, wen};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      wr_gray <= '0;
    end else begin
      wr_ptr  <= ptr_nxt;
      wr_gray <= ptr_nxt ^ (ptr_nxt >> 1);
    end
  end

endmodule

// File: rtl/tfs_sync2.sv
module tfs_sync2 #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/tfs_bitmem.sv
module tfs_bitmem #(
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          din,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          q
);

  localparam int DEPTH = 1 << AW;

  logic store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= din;
  end

  always_ff @(posedge rclk) begin
    if (re) q <= store[raddr];
  end

endmodule

// File: rtl/tfs_rd_ctrl.sv
module tfs_rd_ctrl
  import tfs_pkg::*;
#(
  parameter int PW         = 10,
  parameter int FRAME_BITS = 193,
  parameter int FRAMES_MAX = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    size_sel,
  input  logic [PW-1:0] wr_gray_s,
  input  logic          rd_en,
  input  logic          offs_load,
  input  logic [PW-1:0] offs_val,
  input  logic [1:0]    stat_clr,
  input  logic [1:0]    irq_mask,
  output logic [PW-1:0] rd_addr,
  output logic          rd_step,
  output logic          byp_mode,
  output logic [1:0]    slip_stat,
  output logic          irq
);

  localparam logic [PW-1:0] FR   = PW'(FRAME_BITS);
  localparam logic [PW-1:0] FULL = PW'(FRAME_BITS * FRAMES_MAX);

  function automatic logic [PW-1:0] cap_of(input logic [1:0] code);
    return (code == SZ_ONE || code == SZ_BYPASS) ? FR : FULL;
  endfunction

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [1:0]    sz_q;
  logic [PW-1:0] rd_ptr, ptr_d, w_bin, fill, cap, gap;
  logic          under, over;
  logic [1:0]    slip_set, stat_d;

  assign byp_mode = (sz_q == SZ_BYPASS);

  always_comb begin
    w_bin = gray_to_bin(wr_gray_s);
    cap   = cap_of(sz_q);
    fill  = w_bin - rd_ptr;
    under = fill[PW-1] || (fill == '0);
    over  = !under && (fill >= cap);
    gap   = (offs_val != '0 && offs_val < cap) ? offs_val : (cap >> 1);
  end

  // one read step: normal, repeat a frame (under) or skip a frame (over)
  always_comb begin
    ptr_d    = rd_ptr;
    rd_addr  = rd_ptr;
    rd_step  = 1'b0;
    slip_set = 2'b00;
    if (offs_load) begin
      ptr_d = w_bin - gap;
    end else if (rd_en && !byp_mode) begin
      rd_step = 1'b1;
      if (under) begin
        rd_addr              = rd_ptr - FR;
        slip_set[STAT_UNDER] = 1'b1;
      end else if (over) begin
        rd_addr             = rd_ptr + FR;
        slip_set[STAT_OVER] = 1'b1;
      end
      ptr_d = rd_addr + {{(PW-1){1'b0}}, 1'b1};
    end
    stat_d = (slip_stat & ~stat_clr) | slip_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sz_q      <= size_sel;
      rd_ptr    <= '0 - (cap_of(size_sel) >> 1);
      slip_stat <= '0;
      irq       <= 1'b0;
    end else begin
      sz_q      <= size_sel;
      rd_ptr    <= ptr_d;
      slip_stat <= stat_d;
      irq       <= |(stat_d & ~irq_mask);
    end
  end

endmodule

// File: rtl/tx_frame_store.sv
module tx_frame_store
  import tfs_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int FRAMES_MAX = 2,
  localparam int PW        = $clog2(2 * FRAME_BITS * FRAMES_MAX)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic [1:0]    size_sel,
  input  logic          wr_en,
  input  logic          ser_in,
  input  logic          rd_en,
  input  logic          offs_load,
  input  logic [PW-1:0] offs_val,
  input  logic [1:0]    stat_clr,
  input  logic [1:0]    irq_mask,
  output logic          ser_out,
  output logic [1:0]    slip_stat,
  output logic          irq
);

  logic [PW-1:0] wr_ptr, wr_gray, wr_gray_s, rd_addr;
  logic          rd_step, byp_mode, mem_q, byp_q;

  tfs_wr_ctrl #(.PW(PW)) u_wr (
    .clk(wclk), .rst(rst), .wen(wr_en), .wr_ptr(wr_ptr), .wr_gray(wr_gray)
  );

  tfs_sync2 #(.W(PW)) u_sync (
    .clk(rclk), .rst(rst), .d(wr_gray), .q(wr_gray_s)
  );

  tfs_bitmem #(.AW(PW)) u_mem (
    .wclk(wclk), .we(wr_en), .waddr(wr_ptr), .din(ser_in),
    .rclk(rclk), .re(rd_step), .raddr(rd_addr), .q(mem_q)
  );

  tfs_rd_ctrl #(
    .PW(PW), .FRAME_BITS(FRAME_BITS), .FRAMES_MAX(FRAMES_MAX)
  ) u_rd (
    .clk(rclk), .rst(rst), .size_sel(size_sel), .wr_gray_s(wr_gray_s),
    .rd_en(rd_en), .offs_load(offs_load), .offs_val(offs_val),
    .stat_clr(stat_clr), .irq_mask(irq_mask), .rd_addr(rd_addr),
    .rd_step(rd_step), .byp_mode(byp_mode), .slip_stat(slip_stat), .irq(irq)
  );

  always_ff @(posedge rclk) begin
    if (rst) byp_q <= 1'b0;
    else     byp_q <= ser_in;
  end

  assign ser_out = byp_mode ? byp_q : mem_q;

endmodule

// File: rtl/tfs_checker.sv
module tfs_checker #(
  parameter int PW = 10
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic [1:0]    size_sel,
  input logic          byp_mode,
  input logic          ser_in,
  input logic          ser_out,
  input logic [1:0]    slip_stat,
  input logic [1:0]    stat_clr,
  input logic          irq,
  input logic [PW-1:0] wr_gray
);

  a_r9_sticky_under: assert property (@(posedge rclk) disable iff (rst)
    slip_stat[0] && !stat_clr[0] |=> slip_stat[0]);

  a_r9_sticky_over: assert property (@(posedge rclk) disable iff (rst)
    slip_stat[1] && !stat_clr[1] |=> slip_stat[1]);

  a_r9_one_direction: assert property (@(posedge rclk) disable iff (rst)
    $countones(slip_stat & ~$past(slip_stat)) <= 1);

  a_r1_bypass_quiet: assert property (@(posedge rclk) disable iff (rst)
    byp_mode |=> (slip_stat & ~$past(slip_stat)) == 2'b00);

  a_r1_bypass_latency: assert property (@(posedge rclk) disable iff (rst)
    size_sel == 2'b00 |=> ser_out == $past(ser_in));

  a_r10_irq_source: assert property (@(posedge rclk) disable iff (rst)
    irq |-> slip_stat != 2'b00);

  a_r7_clean_reset: assert property (@(posedge rclk) disable iff (rst)
    $past(rst) |-> slip_stat == 2'b00 && !irq);

  a_r6_gray_step: assert property (@(posedge wclk) disable iff (rst)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

endmodule

bind tx_frame_store tfs_checker #(.PW(PW)) i_tfs_checker (
  .wclk(wclk), .rclk(rclk), .rst(rst), .size_sel(size_sel),
  .byp_mode(byp_mode), .ser_in(ser_in), .ser_out(ser_out),
  .slip_stat(slip_stat), .stat_clr(stat_clr), .irq(irq), .wr_gray(wr_gray)
);

// File: tb/test_tx_frame_store.sv
module test_tx_frame_store;

  localparam int F  = 193;
  localparam int PW = 10;

  logic          wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
  logic [1:0]    size_sel = 2'b01;
  logic          wr_en = 1'b0, ser_in = 1'b0, rd_en = 1'b0, offs_load = 1'b0;
  logic [PW-1:0] offs_val = '0;
  logic [1:0]    stat_clr = 2'b00, irq_mask = 2'b00;
  logic          ser_out, irq;
  logic [1:0]    slip_stat;

  tx_frame_store i_tx_frame_store (
    .wclk(wclk), .rclk(rclk), .rst(rst), .size_sel(size_sel), .wr_en(wr_en),
    .ser_in(ser_in), .rd_en(rd_en), .offs_load(offs_load), .offs_val(offs_val),
    .stat_clr(stat_clr), .irq_mask(irq_mask), .ser_out(ser_out),
    .slip_stat(slip_stat), .irq(irq)
  );

  // 125 MHz on both sides; read edge 3 ns after write edge
  initial forever #4 wclk = ~wclk;
  initial begin #3; forever #4 rclk = ~rclk; end

  int n_cmp = 0, n_bad = 0;
  int wc0, wc1, wc2, idx, cap;
  logic [1:0] exp_stat, mask;
  bit byp, done = 1'b0;

  function automatic int pat(input int i);
    int unsigned h;
    h = 32'(i) * 32'h9E3779B1;
    return int'(h[13] ^ h[21] ^ h[29]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called 2 ns after an rclk edge; drives inputs, waits one edge, checks
  task automatic step(input bit we, input bit re, input bit ld, input int v,
                      input logic [1:0] clr);
    int din, d, a, g;
    logic prev;
    logic [1:0] set;
    string tag;
    din = byp ? int'($urandom % 2) : pat(wc0);
    wr_en = we; ser_in = din[0]; rd_en = re; offs_load = ld;
    offs_val = PW'(v); stat_clr = clr; irq_mask = mask;
    prev = ser_out;
    @(posedge rclk); #2;
    wc2 = wc1; wc1 = wc0; if (we) wc0++;
    set = 2'b00;
    if (byp) begin
      check("R1 bypass output", int'(ser_out), din);
    end else if (ld) begin
      g = (v >= 1 && v < cap) ? v : cap / 2;
      idx = wc2 - g;                       // R8 separation from synced count
      check("R8 load holds output", int'(ser_out), int'(prev));
    end else if (re) begin
      d = wc2 - idx;                        // R6 fill from count two edges back
      a = idx;
      tag = "R5 in-order read";
      if (d <= 0) begin
        a = idx - F; set = 2'b01; tag = "R3 underflow repeats frame";
      end else if (d >= cap) begin
        a = idx + F; set = 2'b10;
        if (cap == 2 * F) tag = "R2 two-frame overflow";
        else              tag = "R4 overflow skips frame";
      end
      idx = a + 1;
      if (a >= 0 && a < wc1 && a > wc0 - 1000) check(tag, int'(ser_out), pat(a));
    end else begin
      check("R5 hold without read", int'(ser_out), int'(prev));
    end
    exp_stat = (exp_stat & ~clr) | set;
    if (set != 2'b00) tag = "R6 slip at threshold";
    else              tag = "R9 sticky status";
    check(tag, int'(slip_stat), int'(exp_stat));
    check("R10 irq", int'(irq), int'(|(exp_stat & ~mask)));
  endtask

  task automatic do_reset(input logic [1:0] sz);
    size_sel = sz; rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    offs_load = 1'b0; stat_clr = 2'b00;
    repeat (4) @(posedge rclk);
    #2;
    check("R7 reset status", int'(slip_stat), 0);
    check("R7 reset irq", int'(irq), 0);
    rst = 1'b0;
    byp = (sz == 2'b00);
    cap = (sz == 2'b00 || sz == 2'b01) ? F : 2 * F;
    wc0 = 0; wc1 = 0; wc2 = 0;
    idx = -(cap / 2);                       // R7 half-size start
    exp_stat = 2'b00;
  endtask

  task automatic run(input int n, input int pw, input int pr);
    for (int i = 0; i < n; i++) begin
      logic [1:0] c;
      c = (($urandom % 3) == 0) ? exp_stat : 2'b00;
      if (($urandom % 7) == 0) c = 2'($urandom % 4);
      step(($urandom % 100) < pw, ($urandom % 100) < pr, 1'b0, 0, c);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mask = 2'b00;

    do_reset(2'b01);
    run(300, 100, 100);
    run(800, 50, 100);          // underflow drift
    run(800, 100, 50);          // overflow drift
    step(1'b1, 1'b1, 1'b1, 10, 2'b00);
    run(60, 100, 100);
    step(1'b1, 1'b1, 1'b1, 0, 2'b00);     // out of range: half
    run(60, 100, 100);
    step(1'b1, 1'b1, 1'b1, F, 2'b00);     // equals capacity: half
    run(60, 100, 100);
    step(1'b1, 1'b1, 1'b1, F - 1, 2'b00); // largest valid
    run(120, 100, 100);
    step(1'b1, 1'b1, 1'b1, 1, 2'b00);     // smallest valid
    run(120, 100, 100);

    do_reset(2'b10);
    mask = 2'b01;
    run(300, 100, 100);
    run(1500, 50, 100);
    run(1500, 100, 50);

    do_reset(2'b11);
    mask = 2'b10;
    run(1200, 60, 100);
    run(1200, 100, 60);
    step(1'b1, 1'b1, 1'b1, 2 * F - 1, 2'b00);
    run(200, 100, 100);

    do_reset(2'b00);
    mask = 2'b00;
    run(300, 50, 100);
    run(300, 100, 50);

    do_reset(2'b01);
    for (int k = 0; k < 10; k++) begin
      mask = 2'($urandom % 4);
      run(200, 40 + int'($urandom % 61), 40 + int'($urandom % 61));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule